// File: doc/BRIEF.md
# Configurable Parallel Pixel Capture Front End

This block sits at the input of a video link transmitter. It samples a 48-bit parallel pixel bus together with horizontal sync, vertical sync and data-enable. The bus is sampled on the rising edge, the falling edge, or both edges of the pixel clock. The block then delivers normalized pixel words in the rising-edge clock domain to the serializer logic that follows. Each output cycle carries up to two pixels. Each pixel has its own valid flag, and the cycle also carries the sync bits.

Two settings are applied at runtime and are independent of each other: a width mode and a capture edge. The width mode selects 18-bit or 24-bit single-pixel operation, or 36-bit or 48-bit double-pixel operation. In the double-pixel modes the low half of the bus holds pixel n and the upper half holds pixel n+1. Dual-edge capture is legal only with the single-pixel widths. In that case the falling-edge sample and the following rising-edge sample are presented together in one cycle.

A requested setting does not take effect until the captured framing shows both data-enable and vertical sync low, so a line is never split across two modes. An illegal combination raises an error flag and suppresses every pixel-valid output until a legal setting is applied.

Top module: `pixcap_front`

## Requirements
- R1: While reset is high, and on the cycle after reset is released, all pixel outputs, both valid flags, both sync outputs and the error flag are zero.
- R2: The width code on `cfg_width` is 00 = 18-bit single, 01 = 24-bit single, 10 = 36-bit double, 11 = 48-bit double. In the 24-bit single rising mode, `out_pix0` equals bus bits [23:0] as sampled at a rising edge. The value appears after the second rising edge following that sample, and `out_pix1` and `out_vld1` are zero.
- R3: In the 18-bit and 36-bit modes each output pixel keeps only its low 18 bits, and bits [23:18] of both pixel outputs are zero.
- R4: The edge code on `cfg_edge` is 00 = rising, 01 = falling, 1x = both. In falling mode the output pixel is the bus value sampled at the falling edge before the rising edge that a rising-mode capture would use, with the same output latency.
- R5: In both-edge mode with a single-pixel width, `out_pix0`/`out_vld0` carry the falling-edge sample and `out_pix1`/`out_vld1` carry the following rising-edge sample. Each valid flag follows its own sample's data-enable.
- R6: In the double-pixel modes one sample yields two pixels. Pixel n comes from bus [23:0] and pixel n+1 from bus [47:24], or from [17:0] and [41:24] in the 36-bit mode. Both valid flags follow that sample's data-enable.
- R7: A pixel-valid flag is high only if the data-enable captured with that pixel is high. The sync outputs pass through whatever the value of data-enable.
- R8: The combination of both-edge capture with a double-pixel width sets `cfg_err`, and while it is active both valid flags are zero. Applying a legal combination clears `cfg_err` and restores valid output.
- R9: A new width or edge setting is applied only on a cycle where the captured data-enable and vertical sync of both samples are low. While data-enable stays high, the previous mode remains in effect.
- R10: The sync outputs come from the falling-edge sample in falling mode, and from the rising-edge sample in rising and both-edge modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; outputs are in its rising-edge domain |
| rst | input | 1 | Synchronous active-high reset |
| pix_bus | input | 48 | Parallel pixel data bus |
| hsync_in | input | 1 | Horizontal sync from the source |
| vsync_in | input | 1 | Vertical sync from the source |
| de_in | input | 1 | Data-enable from the source |
| cfg_width | input | 2 | Requested width mode (see R2) |
| cfg_edge | input | 2 | Requested capture edge (see R4) |
| out_pix0 | output | 24 | First (or only) pixel of the cycle |
| out_pix1 | output | 24 | Second pixel of the cycle |
| out_vld0 | output | 1 | Valid flag for out_pix0 |
| out_vld1 | output | 1 | Valid flag for out_pix1 |
| out_hsync | output | 1 | Captured horizontal sync |
| out_vsync | output | 1 | Captured vertical sync |
| cfg_err | output | 1 | Illegal width/edge combination in effect |

## Verification
Two functions can meet in the same cycle: a mode change, and a line that is still active. The bench writes a new width onto the configuration inputs while data-enable is held high. It then drives a full-scale pixel and expects it back unmasked in the old 24-bit mode. It lowers data-enable and expects the 18-bit mask only after that. The illegal both-edge double-pixel setting is also applied together with active pixels, and is judged by `cfg_err` rising while both valid flags stay low.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;
  typedef enum logic [1:0] {
    W18 = 2'b00,
    W24 = 2'b01,
    W36 = 2'b10,
    W48 = 2'b11
  } width_e;

  typedef enum logic [1:0] {
    E_RISE     = 2'b00,
    E_FALL     = 2'b01,
    E_BOTH     = 2'b10,
    E_BOTH_ALT = 2'b11
  } edge_e;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } frame_t;
endpackage

// File: rtl/pixcap_edge_banks.sv
module pixcap_edge_banks
  import pixcap_pkg::*;
#(
  parameter int BUS_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] bus_in,
  input  frame_t           frm_in,
  output logic [BUS_W-1:0] rise_bus,
  output frame_t           rise_frm,
  output logic [BUS_W-1:0] fall_bus,
  output frame_t           fall_frm
);
  logic [BUS_W-1:0] neg_bus;
  frame_t           neg_frm;

  // Falling-edge bank.
  always_ff @(negedge clk) begin
    if (rst) begin
      neg_bus <= '0;
      neg_frm <= '0;
    end else begin
      neg_bus <= bus_in;
      neg_frm <= frm_in;
    end
  end

  // Rising-edge bank plus transfer of the preceding falling sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_bus <= '0;
      rise_frm <= '0;
      fall_bus <= '0;
      fall_frm <= '0;
    end else begin
      rise_bus <= bus_in;
      rise_frm <= frm_in;
      fall_bus <= neg_bus;
      fall_frm <= neg_frm;
    end
  end
endmodule

// File: rtl/pixcap_cfg_ctrl.sv
module pixcap_cfg_ctrl
  import pixcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req_width,
  input  logic [1:0] req_edge,
  input  logic       rise_de,
  input  logic       rise_vs,
  input  logic       fall_de,
  input  logic       fall_vs,
  output width_e     act_w,
  output edge_e      act_e,
  output logic       illegal,
  output logic       err_q
);
  logic idle;

  assign idle    = !rise_de && !rise_vs && !fall_de && !fall_vs;
  assign illegal = act_w[1] && act_e[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_w <= width_e'(req_width);
      act_e <= edge_e'(req_edge);
      err_q <= 1'b0;
    end else begin
      if (idle) begin
        act_w <= width_e'(req_width);
        act_e <= edge_e'(req_edge);
      end
      err_q <= illegal;
    end
  end

  // R9
  cfg_hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !idle |=> ($stable(act_w) && $stable(act_e)));

  // R8
  err_follows_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |=> err_q);
endmodule

// File: rtl/pixcap_pack.sv
module pixcap_pack
  import pixcap_pkg::*;
#(
  parameter int PIX_W    = 24,
  parameter int NARROW_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*PIX_W-1:0] rise_bus,
  input  frame_t             rise_frm,
  input  logic [2*PIX_W-1:0] fall_bus,
  input  frame_t             fall_frm,
  input  width_e             act_w,
  input  edge_e              act_e,
  input  logic               illegal,
  output logic [PIX_W-1:0]   pix0,
  output logic [PIX_W-1:0]   pix1,
  output logic               vld0,
  output logic               vld1,
  output logic               hs,
  output logic               vs
);
  localparam int LANES = 2;
  localparam int PAD_W = PIX_W - NARROW_W;

  logic               narrow, dbl, both, use_fall;
  logic [2*PIX_W-1:0] sel_bus;
  frame_t             sel_frm;
  logic [PIX_W-1:0]   sel_lane  [LANES];
  logic [PIX_W-1:0]   fall_lo, rise_lo;
  logic [PIX_W-1:0]   d0, d1;
  logic               dv0, dv1;

  function automatic logic [PIX_W-1:0] trim(input logic [PIX_W-1:0] x, input logic nar);
    return nar ? {{PAD_W{1'b0}}, x[NARROW_W-1:0]} : x;
  endfunction

  assign narrow   = (act_w == W18) || (act_w == W36);
  assign dbl      = act_w[1];
  assign both     = act_e[1];
  assign use_fall = (act_e == E_FALL);
  assign sel_bus  = use_fall ? fall_bus : rise_bus;
  assign sel_frm  = use_fall ? fall_frm : rise_frm;
  assign fall_lo  = trim(fall_bus[PIX_W-1:0], narrow);
  assign rise_lo  = trim(rise_bus[PIX_W-1:0], narrow);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign sel_lane[l] = trim(sel_bus[l*PIX_W +: PIX_W], narrow);
  end

  always_comb begin
    if (dbl) begin
      d0  = sel_lane[0];
      d1  = sel_lane[1];
      dv0 = sel_frm.de;
      dv1 = sel_frm.de;
    end else if (both) begin
      d0  = fall_lo;
      d1  = rise_lo;
      dv0 = fall_frm.de;
      dv1 = rise_frm.de;
    end else begin
      d0  = sel_lane[0];
      d1  = '0;
      dv0 = sel_frm.de;
      dv1 = 1'b0;
    end
    if (illegal) begin
      dv0 = 1'b0;
      dv1 = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix0 <= '0;
      pix1 <= '0;
      vld0 <= 1'b0;
      vld1 <= 1'b0;
      hs   <= 1'b0;
      vs   <= 1'b0;
    end else begin
      pix0 <= d0;
      pix1 <= d1;
      vld0 <= dv0;
      vld1 <= dv1;
      hs   <= sel_frm.hs;
      vs   <= sel_frm.vs;
    end
  end

  // R8
  no_valid_when_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (!vld0 && !vld1));

  // R3
  narrow_mask_chk: assert property (@(posedge clk) disable iff (rst)
    narrow |=> (pix0[PIX_W-1:NARROW_W] == '0 && pix1[PIX_W-1:NARROW_W] == '0));

  // R2
  single_no_second_chk: assert property (@(posedge clk) disable iff (rst)
    (!dbl && !both) |=> (!vld1 && pix1 == '0));
endmodule

// File: rtl/pixcap_front.sv
module pixcap_front
  import pixcap_pkg::*;
#(
  parameter int PIX_W    = 24,
  parameter int NARROW_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*PIX_W-1:0] pix_bus,
  input  logic               hsync_in,
  input  logic               vsync_in,
  input  logic               de_in,
  input  logic [1:0]         cfg_width,
  input  logic [1:0]         cfg_edge,
  output logic [PIX_W-1:0]   out_pix0,
  output logic [PIX_W-1:0]   out_pix1,
  output logic               out_vld0,
  output logic               out_vld1,
  output logic               out_hsync,
  output logic               out_vsync,
  output logic               cfg_err
);
  localparam int BUS_W = 2 * PIX_W;

  frame_t           in_frm, rise_frm, fall_frm;
  logic [BUS_W-1:0] rise_bus, fall_bus;
  width_e           act_w;
  edge_e            act_e;
  logic             illegal;

  assign in_frm = '{hs: hsync_in, vs: vsync_in, de: de_in};

  pixcap_edge_banks #(.BUS_W(BUS_W)) u_banks (
    .clk      (clk),
    .rst      (rst),
    .bus_in   (pix_bus),
    .frm_in   (in_frm),
    .rise_bus (rise_bus),
    .rise_frm (rise_frm),
    .fall_bus (fall_bus),
    .fall_frm (fall_frm)
  );

  pixcap_cfg_ctrl u_cfg (
    .clk       (clk),
    .rst       (rst),
    .req_width (cfg_width),
    .req_edge  (cfg_edge),
    .rise_de   (rise_frm.de),
    .rise_vs   (rise_frm.vs),
    .fall_de   (fall_frm.de),
    .fall_vs   (fall_frm.vs),
    .act_w     (act_w),
    .act_e     (act_e),
    .illegal   (illegal),
    .err_q     (cfg_err)
  );

  pixcap_pack #(.PIX_W(PIX_W), .NARROW_W(NARROW_W)) u_pack (
    .clk      (clk),
    .rst      (rst),
    .rise_bus (rise_bus),
    .rise_frm (rise_frm),
    .fall_bus (fall_bus),
    .fall_frm (fall_frm),
    .act_w    (act_w),
    .act_e    (act_e),
    .illegal  (illegal),
    .pix0     (out_pix0),
    .pix1     (out_pix1),
    .vld0     (out_vld0),
    .vld1     (out_vld1),
    .hs       (out_hsync),
    .vs       (out_vsync)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_vld0 && !out_vld1 && !cfg_err && out_pix0 == '0));
endmodule

// File: tb/tb_pixcap_front.sv
`timescale 1ns/1ps
module tb_pixcap_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] pix_bus = '0;
  logic        hsync_in = 1'b0, vsync_in = 1'b0, de_in = 1'b0;
  logic [1:0]  cfg_width = 2'b01, cfg_edge = 2'b00;
  logic [23:0] out_pix0, out_pix1;
  logic        out_vld0, out_vld1, out_hsync, out_vsync, cfg_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [2:0] F_IDLE = 3'b000;  // {hs,vs,de}
  localparam logic [2:0] F_DE   = 3'b001;

  always #4 clk = ~clk;

  pixcap_front dut (.*);

  task automatic chk(input string tag, input string what, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic expect_out(input string tag, input logic [23:0] p0, input logic [23:0] p1,
                            input logic v0, input logic v1);
    chk(tag, "pix0", {24'h0, out_pix0}, {24'h0, p0});
    chk(tag, "pix1", {24'h0, out_pix1}, {24'h0, p1});
    chk(tag, "vld0", {47'h0, out_vld0}, {47'h0, v0});
    chk(tag, "vld1", {47'h0, out_vld1}, {47'h0, v1});
  endtask

  // Value a is taken by the falling edge, value b by the next rising edge.
  task automatic cyc(input logic [47:0] a_bus, input logic [2:0] a_f,
                     input logic [47:0] b_bus, input logic [2:0] b_f);
    @(posedge clk); #2;
    pix_bus = a_bus; {hsync_in, vsync_in, de_in} = a_f;
    #4;
    pix_bus = b_bus; {hsync_in, vsync_in, de_in} = b_f;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic set_cfg(input logic [1:0] w, input logic [1:0] e);
    @(posedge clk); #2;
    {hsync_in, vsync_in, de_in} = F_IDLE;
    cfg_width = w; cfg_edge = e;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset();
    #1;
    expect_out("R1", 24'h0, 24'h0, 1'b0, 1'b0);
    chk("R1", "cfg_err", {47'h0, cfg_err}, 48'h0);
    chk("R1", "hsync", {47'h0, out_hsync}, 48'h0);
  endtask

  task automatic t_rise24();
    set_cfg(2'b01, 2'b00);
    cyc(48'h111111_222222, F_IDLE, 48'h999999_123456, F_DE);
    settle();
    expect_out("R2", 24'h123456, 24'h0, 1'b1, 1'b0);
  endtask

  task automatic t_rise18();
    set_cfg(2'b00, 2'b00);
    cyc(48'h0, F_IDLE, 48'hFFFFFF_FFFFFF, F_DE);
    settle();
    expect_out("R3", 24'h03FFFF, 24'h0, 1'b1, 1'b0);
  endtask

  task automatic t_fall24();
    set_cfg(2'b01, 2'b01);
    cyc(48'h000000_ABCDEF, F_DE, 48'h000000_555555, F_IDLE);
    settle();
    expect_out("R4", 24'hABCDEF, 24'h0, 1'b1, 1'b0);
  endtask

  task automatic t_both24();
    set_cfg(2'b01, 2'b10);
    cyc(48'h0, F_DE, 48'h0, F_DE);  // settle a known pair first
    cyc(48'h777777_00A0B0, 3'b000, 48'h888888_C0D0E0, 3'b101);
    settle();
    expect_out("R5", 24'h00A0B0, 24'hC0D0E0, 1'b0, 1'b1);
    chk("R10", "hsync both mode", {47'h0, out_hsync}, 48'h1);
  endtask

  task automatic t_dbl48();
    set_cfg(2'b11, 2'b00);
    cyc(48'h0, F_IDLE, 48'h654321_ABCDEF, F_DE);
    settle();
    expect_out("R6", 24'hABCDEF, 24'h654321, 1'b1, 1'b1);
  endtask

  task automatic t_dbl36();
    set_cfg(2'b10, 2'b01);
    cyc(48'hFFFFFF_FFFFFF, F_DE, 48'h0, F_IDLE);
    settle();
    expect_out("R6", 24'h03FFFF, 24'h03FFFF, 1'b1, 1'b1);
    chk("R3", "36-bit upper mask", {24'h0, out_pix1 & 24'hFC0000}, 48'h0);
  endtask

  task automatic t_sync_no_de();
    set_cfg(2'b01, 2'b00);
    cyc(48'h0, F_IDLE, 48'h000000_424242, 3'b110);
    settle();
    chk("R7", "vld0 with de low", {47'h0, out_vld0}, 48'h0);
    chk("R7", "hsync pass", {47'h0, out_hsync}, 48'h1);
    chk("R7", "vsync pass", {47'h0, out_vsync}, 48'h1);
  endtask

  task automatic t_fall_sync();
    set_cfg(2'b01, 2'b01);
    cyc(48'h0, 3'b101, 48'h0, 3'b000);
    settle();
    chk("R10", "hsync falling source", {47'h0, out_hsync}, 48'h1);
  endtask

  task automatic t_illegal();
    set_cfg(2'b11, 2'b10);
    cyc(48'h123456_654321, F_DE, 48'h123456_654321, F_DE);
    settle();
    chk("R8", "cfg_err set", {47'h0, cfg_err}, 48'h1);
    chk("R8", "vld0 suppressed", {47'h0, out_vld0}, 48'h0);
    chk("R8", "vld1 suppressed", {47'h0, out_vld1}, 48'h0);
    set_cfg(2'b01, 2'b00);
    cyc(48'h0, F_IDLE, 48'h000000_0F0F0F, F_DE);
    settle();
    chk("R8", "cfg_err cleared", {47'h0, cfg_err}, 48'h0);
    expect_out("R8", 24'h0F0F0F, 24'h0, 1'b1, 1'b0);
  endtask

  task automatic t_defer();
    set_cfg(2'b01, 2'b00);
    cyc(48'h0, F_DE, 48'h0, F_DE);
    cyc(48'h0, F_DE, 48'h0, F_DE);
    cfg_width = 2'b00;  // request 18-bit while the line is active
    cyc(48'hFFFFFF_FFFFFF, F_DE, 48'hFFFFFF_FFFFFF, F_DE);
    settle();
    expect_out("R9", 24'hFFFFFF, 24'h0, 1'b1, 1'b0);
    set_cfg(2'b00, 2'b00);
    cyc(48'h0, F_IDLE, 48'hFFFFFF_FFFFFF, F_DE);
    settle();
    expect_out("R9", 24'h03FFFF, 24'h0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(posedge clk); #2;
    rst = 1'b0;
    t_rise24();
    t_rise18();
    t_fall24();
    t_both24();
    t_dbl48();
    t_dbl36();
    t_sync_no_de();
    t_fall_sync();
    t_illegal();
    t_defer();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule